// File: doc/BRIEF.md
# Cross-Tile Row Response Comparator

This block judges one full memory row read during a tiled neighbourhood test. The row is split into tiles three columns wide, and every tile is driven with the same pattern sequence. In a fault-free array every tile therefore reads back the same three bits. The block needs no expected data word. It takes the first tile as the reference. Each other column is compared with the reference column at the same tile position. Any column that disagrees is reported.

A read is presented as a whole row together with a one-cycle valid strobe. One clock later the block returns a pass/fail flag and a per-column mismatch mask. A sticky error bit gathers every failure across a test run, and a clear pulse resets it between runs. The row width is a parameter of at least three columns. When the width is not a multiple of three, the last tile is partial and is compared only at the positions it holds.

Top module: `row_consensus_checker`

## Requirements
- R1: While reset is low at a clock edge, `fail`, `mis_mask` and `err_sticky` are all 0 after that edge.
- R2: Column c (bit c of `rd_row`) belongs to tile position c mod 3. After an edge that samples `rd_valid`=1, `mis_mask[c]` is 1 exactly when `rd_row[c]` differs from `rd_row[c mod 3]`.
- R3: Columns 0, 1 and 2 form the reference tile and are never flagged in `mis_mask`. A fault in a reference column instead flags every other column at that position that still holds the good value.
- R4: `fail` equals the OR of `mis_mask` and appears on the edge that samples the valid read, so it is visible for one cycle after the strobe.
- R5: After an edge that samples `rd_valid`=0, `fail` and `mis_mask` are 0, whatever `rd_row` holds.
- R6: When the width is not a multiple of 3, each column of the trailing partial tile is compared with the reference column at its own position and with no other column.
- R7: `err_sticky` goes to 1 on the same edge that raises `fail` and stays at 1 until a clear.
- R8: An edge that samples `clr_err`=1 clears `err_sticky`, unless the same edge also samples a failing read. In that case the new failure wins and `err_sticky` stays 1.
- R9: A row in which every tile holds the same bits passes (`fail`=0) for all eight tile patterns, including the partial tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_valid | input | 1 | Strobe: `rd_row` holds a row read this cycle |
| rd_row | input | ROW_W | Complete row of read data, column c on bit c |
| clr_err | input | 1 | Clears the sticky error bit |
| fail | output | 1 | Registered result of the last cycle: 1 if any column disagreed |
| mis_mask | output | ROW_W | Registered per-column mismatch mask |
| err_sticky | output | 1 | Set by any failure, held until cleared |

## Verification
All three results (`fail`, `mis_mask` and the update of `err_sticky`) are due on the first rising edge after the row is presented with the strobe. The bench drives inputs on the falling edge and drops the strobe on the following falling edge. It samples the outputs at that same falling edge, half a cycle after the result edge. A check one cycle later confirms that the results return to zero once the strobe is gone. The sticky bit is compared against a running model that the bench updates on every edge that samples a read or a clear.

// File: rtl/row_cmp_pkg.sv
// Package: shared constants and helpers for the cross-tile row comparator.
// Assumes tiles are exactly three columns wide and start at column 0.
package row_cmp_pkg;
    localparam int TILE_W = 3;

    // Reference column (in the first tile) for a given column index.
    function automatic int ref_col(input int col);
        return col % TILE_W;
    endfunction
endpackage

// File: rtl/col_mismatch.sv
// Module: combinational per-column disagreement detector.
// Compares every column with the column at the same tile position in the
// first tile. Reference columns are never flagged. A trailing partial
// tile is handled naturally because each column only looks at its own
// reference. Assumes ROW_W >= TILE_W.
module col_mismatch
    import row_cmp_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] mask
);
    if (ROW_W < TILE_W) begin : g_width_bad
        $error("col_mismatch: ROW_W must be at least one tile wide");
    end

    // Reference tile: no comparison partner, never flagged.
    for (genvar c = 0; c < TILE_W; c++) begin : g_ref
        assign mask[c] = 1'b0;
    end

    // Every later column, including a partial last tile, against its reference.
    for (genvar c = TILE_W; c < ROW_W; c++) begin : g_cmp
        localparam int RC = ref_col(c);
        assign mask[c] = row[c] ^ row[RC];
    end
endmodule

// File: rtl/result_reg.sv
// Module: registers the mismatch mask and pass/fail flag for one cycle,
// and keeps a sticky error bit. A new failure wins over a same-cycle clear.
// Assumes the strobe is sampled on the same edge as the mask.
module result_reg #(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [ROW_W-1:0] mask_in,
    input  logic             clr,
    output logic             fail,
    output logic [ROW_W-1:0] mask_q,
    output logic             err_sticky
);
    logic new_fail;

    // Failure of the read being sampled on this edge.
    always_comb new_fail = valid & (|mask_in);

    // Result register: holds the mask only for a cycle after a valid read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail   <= 1'b0;
            mask_q <= '0;
        end else begin
            fail   <= new_fail;
            mask_q <= valid ? mask_in : '0;
        end
    end

    // Sticky error: collects failures; clear yields to a simultaneous failure.
    always_ff @(posedge clk) begin
        if (!rst_n) err_sticky <= 1'b0;
        else        err_sticky <= (err_sticky & ~clr) | new_fail;
    end

    // R5
    no_result_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!fail && mask_q == '0));
    // R7
    sticky_follows_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> err_sticky);
    // R7
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !clr) |=> err_sticky);
    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !valid) |=> !err_sticky);
endmodule

// File: rtl/row_consensus_checker.sv
// Module: top of the cross-tile row response comparator.
// Takes a full row read, checks that all 3-column tiles agree with the first
// tile at each position, and returns a registered fail flag, a per-column
// mismatch mask and a sticky error bit. Needs no expected data.
module row_consensus_checker #(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic [ROW_W-1:0] rd_row,
    input  logic             clr_err,
    output logic             fail,
    output logic [ROW_W-1:0] mis_mask,
    output logic             err_sticky
);
    logic [ROW_W-1:0] raw_mask;

    // Combinational comparison of every column against its reference.
    col_mismatch #(.ROW_W(ROW_W)) u_cmp (
        .row  (rd_row),
        .mask (raw_mask)
    );

    // Output and sticky registers.
    result_reg #(.ROW_W(ROW_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (rd_valid),
        .mask_in    (raw_mask),
        .clr        (clr_err),
        .fail       (fail),
        .mask_q     (mis_mask),
        .err_sticky (err_sticky)
    );

    // R9
    zero_row_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_row == '0) |=> !fail);
    // R4
    fail_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail == (mis_mask != '0));
    // R3
    ref_tile_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis_mask[2:0] == 3'b000);
endmodule

// File: tb/tb_row_consensus_checker.sv
module tb_row_consensus_checker;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_valid = 1'b0;
    logic [W-1:0] rd_row = '0;
    logic         clr_err = 1'b0;
    logic         fail;
    logic [W-1:0] mis_mask;
    logic         err_sticky;

    int checks = 0;
    int failures = 0;
    logic exp_err = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    row_consensus_checker #(.ROW_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_row(rd_row),
        .clr_err(clr_err), .fail(fail), .mis_mask(mis_mask), .err_sticky(err_sticky)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_mask(input logic [W-1:0] r);
        logic [W-1:0] m = '0;
        for (int c = 3; c < W; c++) m[c] = r[c] ^ r[c % 3];
        return m;
    endfunction

    function automatic logic [W-1:0] tile_row(input logic [2:0] t);
        logic [W-1:0] r;
        for (int c = 0; c < W; c++) r[c] = t[c % 3];
        return r;
    endfunction

    // Present one row with the strobe, plus an optional clear, then check results.
    task automatic apply(input logic [W-1:0] r, input bit clr, input string req);
        logic [W-1:0] em;
        @(negedge clk);
        rd_valid = 1'b1; rd_row = r; clr_err = clr;
        @(negedge clk);
        rd_valid = 1'b0; clr_err = 1'b0;
        em = exp_mask(r);
        exp_err = (exp_err & ~clr) | (em != '0);
        check(mis_mask == em, {req, " mask"}, mis_mask, em);
        check(fail == (em != '0), {req, " fail R4"}, W'(fail), W'(em != '0));
        check(err_sticky == exp_err, {req, " sticky R7"}, W'(err_sticky), W'(exp_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, with a junk strobe held during reset
        rd_valid = 1'b1; rd_row = 16'hA5A5;
        repeat (3) @(negedge clk);
        check(fail == 1'b0 && mis_mask == '0 && err_sticky == 1'b0, "R1 reset",
              {mis_mask[W-3:0], fail, err_sticky}, '0);
        rd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R9: uniform rows for all tile patterns pass
        for (int t = 0; t < 8; t++) apply(tile_row(3'(t)), 1'b0, "R9 uniform");

        // R2: single-cell fault in each non-reference column, every pattern
        for (int t = 0; t < 8; t++)
            for (int c = 3; c < W; c++) begin
                apply(tile_row(3'(t)) ^ (W'(1) << c), 1'b0, "R2 single cell");
                apply(tile_row(3'(t)), 1'b1, "R8 clear after pass");
            end

        // R3: fault in a reference column flags all peers at that position
        for (int p = 0; p < 3; p++)
            apply(tile_row(3'b010) ^ (W'(1) << p), 1'b0, "R3 ref fault");

        // R6: partial tile column 15 (position 0) alone disagrees
        apply(tile_row(3'b101) ^ (W'(1) << 15), 1'b0, "R6 partial tile");

        // Same position faulty in every non-first tile
        for (int p = 0; p < 3; p++) begin
            logic [W-1:0] f = '0;
            for (int c = 3; c < W; c++) if (c % 3 == p) f[c] = 1'b1;
            apply(tile_row(3'b011) ^ f, 1'b0, "R2 multi-tile same position");
        end

        // R8: clear together with a failing read, the failure wins
        apply(tile_row(3'b000) ^ (W'(1) << 4), 1'b1, "R8 clear vs fail");
        // R8: clear together with a passing read clears
        apply(tile_row(3'b111), 1'b1, "R8 clear");

        // R5: no strobe, a disagreeing row is ignored
        @(negedge clk);
        rd_row = 16'h1234;
        @(negedge clk);
        check(fail == 1'b0 && mis_mask == '0, "R5 no valid", mis_mask, '0);
        check(err_sticky == exp_err, "R5 sticky unchanged", W'(err_sticky), W'(exp_err));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule